// File: doc/BRIEF.md
# Audio Bit and Frame Clock Divider

This block turns a master clock into the two timing signals an audio serial port needs: a bit clock and a left/right frame clock. The bit clock runs at one half or one quarter of the master rate. The frame clock is counted in whole bit-clock periods, and one frame lasts 32, 64 or 128 bit periods. Both outputs are registered in the master clock domain and have a 50 percent duty cycle. Every frame-clock transition falls in the same master cycle as a falling edge of the bit clock.

One enable bit controls both dividers. While the enable is low, both outputs are held low, both counters sit at zero, and the divide fields pass straight into the active settings. After the enable is set, the two outputs start from a known, aligned phase. If a divide field changes while the block is running, the new value is captured only at the next frame boundary, which is the falling edge of the frame clock. A frame that has already started therefore always finishes with the ratios it began with.

Top module: `audio_clk_div`

## Requirements
- R1: While rst_n is low, bclk_o and fclk_o are both low at every sampled cycle, whatever the other inputs are.
- R2: With the active bit field at 0, a bit-clock period is 2 master cycles: 1 cycle high followed by 1 cycle low.
- R3: With the active bit field at 1, a bit-clock period is 4 master cycles: 2 cycles high followed by 2 cycles low.
- R4: Frame codes 0, 1 and 2 give 32, 64 and 128 bit-clock periods (rising edges) per frame-clock period.
- R5: Frame codes 3 to 7 behave exactly like code 2 (128 bit periods per frame).
- R6: The frame clock is high for exactly half of each frame period, counted in master cycles.
- R7: While the enable stays high, every change of fclk_o happens in the same master cycle as a falling edge of bclk_o.
- R8: One master cycle after en is sampled low, both outputs are low, and they stay low while en remains low. Once en is sampled high, bclk_o first goes high after P/2 master cycles and fclk_o first goes high after P*N/2 master cycles, where P is the bit ratio and N the frame ratio.
- R9: A change to either divide field while the block is running first takes effect in the frame that follows the next falling edge of fclk_o. While en is low, the field values are taken over directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Shared enable for both dividers |
| bclk_sel | input | 1 | Bit-clock ratio: 0 gives /2, 1 gives /4 |
| frame_sel | input | 3 | Frame ratio code: 0 gives 32, 1 gives 64, 2 to 7 give 128 bit periods |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Frame (left/right) clock |

## Verification
The assertions assume that en and both divide fields are synchronous to the master clock. They also assume that en is driven to a defined level while reset is applied, because the properties that look one cycle back read en across the reset boundary. The stimulus changes every input only at falling master edges and holds en low for at least two cycles before each new setting. It changes a field during a running frame only in the directed frame-boundary test, which exercises the capture rule on purpose.

// File: rtl/acd_pkg.sv
// Package acd_pkg
// Shared ratio constants and helpers for the audio clock divider.
// Assumes frame codes above FRAME_TOP_CODE are folded onto the top code.
package acd_pkg;
    localparam int BIT_BASE_LOG2   = 1;   // bit field 0 divides by 2**1
    localparam int FRAME_BASE_LOG2 = 5;   // frame code 0 is 2**5 bit periods
    localparam int FRAME_TOP_CODE  = 2;   // highest distinct frame code

    // Fold an out-of-range frame code onto the longest frame.
    function automatic int frame_step(input int code);
        return (code > FRAME_TOP_CODE) ? FRAME_TOP_CODE : code;
    endfunction
endpackage

// File: rtl/acd_ratio_hold.sv
// Module acd_ratio_hold
// Holds the active divide settings and turns them into counter limits.
// The settings follow the inputs while the dividers are stopped and are
// captured again only at a frame boundary while the dividers run.
module acd_ratio_hold #(
    parameter int BSEL_W = 1,
    parameter int FSEL_W = 3,
    parameter int MC_W   = 2,
    parameter int BC_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              frame_wrap,
    input  logic [BSEL_W-1:0] bsel_i,
    input  logic [FSEL_W-1:0] fsel_i,
    output logic [MC_W-1:0]   bit_last,
    output logic [MC_W-1:0]   bit_half,
    output logic [BC_W-1:0]   frame_last,
    output logic [BC_W-1:0]   frame_half
);
    import acd_pkg::*;

    logic [BSEL_W-1:0] bsel_q;
    logic [FSEL_W-1:0] fsel_q;
    int                bit_log2;
    int                frame_log2;

    // Capture the fields when stopped or at the end of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bsel_q <= '0;
            fsel_q <= '0;
        end else if (!run || frame_wrap) begin
            bsel_q <= bsel_i;
            fsel_q <= fsel_i;
        end
    end

    // Derive last-count and half-period thresholds from the settings.
    always_comb begin
        bit_log2   = BIT_BASE_LOG2 + int'(bsel_q);
        frame_log2 = FRAME_BASE_LOG2 + frame_step(int'(fsel_q));
        bit_last   = MC_W'((1 << bit_log2) - 1);
        bit_half   = MC_W'(1 << (bit_log2 - 1));
        frame_last = BC_W'((1 << frame_log2) - 1);
        frame_half = BC_W'(1 << (frame_log2 - 1));
    end
endmodule

// File: rtl/acd_phase_stage.sv
// Module acd_phase_stage
// One divider stage: counts steps from 0 to a last value and drives a
// registered square wave that is low in the first half of each period.
// Assumes last+1 is even and half equals (last+1)/2.
module acd_phase_stage #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic [CNT_W-1:0] last,
    input  logic [CNT_W-1:0] half,
    output logic             wrap,
    output logic             wave_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_n;

    // Next count: cleared when stopped, advanced on each step.
    always_comb begin
        if (!run)
            cnt_n = '0;
        else if (step)
            cnt_n = (cnt_q == last) ? '0 : cnt_q + 1'b1;
        else
            cnt_n = cnt_q;
        wrap = run && step && (cnt_q == last);
    end

    // Register the count and the square wave derived from the next count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wave_o <= 1'b0;
        end else begin
            cnt_q  <= cnt_n;
            wave_o <= run && (cnt_n >= half);
        end
    end
endmodule

// File: rtl/audio_clk_div.sv
// Module audio_clk_div
// Top level: a bit-clock stage that steps every master cycle, chained into
// a frame stage that steps once per bit period. One enable drives both.
// Assumes every input is synchronous to clk.
module audio_clk_div #(
    parameter int BSEL_W = 1,
    parameter int FSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [BSEL_W-1:0] bclk_sel,
    input  logic [FSEL_W-1:0] frame_sel,
    output logic              bclk_o,
    output logic              fclk_o
);
    import acd_pkg::*;

    localparam int MC_W = BIT_BASE_LOG2 + (2 ** BSEL_W) - 1;
    localparam int BC_W = FRAME_BASE_LOG2 + FRAME_TOP_CODE;

    logic [MC_W-1:0] bit_last;
    logic [MC_W-1:0] bit_half;
    logic [BC_W-1:0] frame_last;
    logic [BC_W-1:0] frame_half;
    logic            bit_wrap;
    logic            frame_wrap;

    acd_ratio_hold #(
        .BSEL_W(BSEL_W), .FSEL_W(FSEL_W), .MC_W(MC_W), .BC_W(BC_W)
    ) u_hold (
        .clk(clk), .rst_n(rst_n), .run(en), .frame_wrap(frame_wrap),
        .bsel_i(bclk_sel), .fsel_i(frame_sel),
        .bit_last(bit_last), .bit_half(bit_half),
        .frame_last(frame_last), .frame_half(frame_half)
    );

    acd_phase_stage #(.CNT_W(MC_W)) u_bit (
        .clk(clk), .rst_n(rst_n), .run(en), .step(1'b1),
        .last(bit_last), .half(bit_half),
        .wrap(bit_wrap), .wave_o(bclk_o)
    );

    acd_phase_stage #(.CNT_W(BC_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .run(en), .step(bit_wrap),
        .last(frame_last), .half(frame_half),
        .wrap(frame_wrap), .wave_o(fclk_o)
    );
endmodule

// File: rtl/acd_checker.sv
// Module acd_checker
// Port-level properties of the audio clock divider, bound to the top.
// Assumes en holds a defined level while reset is asserted.
module acd_checker (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic bclk_o,
    input logic fclk_o
);
    // R8: a low enable forces both outputs low on the next cycle.
    a_r8_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!bclk_o && !fclk_o));

    // R2/R3: the bit clock is never high for more than two cycles in a row.
    a_r3_bclk_high_max: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_o && $past(bclk_o)) |=> !bclk_o);

    // R7: while running, frame edges line up with bit-clock falling edges.
    a_r7_frame_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && (fclk_o != $past(fclk_o))) |-> $fell(bclk_o));

    // R8: the frame clock rises only after an enabled cycle.
    a_r8_rise_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fclk_o) |-> $past(en));

    // R1: reset holds both outputs low.
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> (!bclk_o && !fclk_o));
endmodule

bind audio_clk_div acd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .bclk_o(bclk_o), .fclk_o(fclk_o)
);

// File: tb/sim_audio_clk_div.sv
`timescale 1ns/1ps
module sim_audio_clk_div;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       bclk_sel = 1'b0;
    logic [2:0] frame_sel = 3'd0;
    logic       bclk_o;
    logic       fclk_o;
    int         n_tests = 0;
    int         n_fail = 0;

    // Vector table: bit field, frame code, expected bit ratio, expected frame ratio.
    localparam int NV = 16;
    localparam int VB [NV] = '{0,0,0,0,0,0,0,0,1,1,1,1,1,1,1,1};
    localparam int VF [NV] = '{0,1,2,3,4,5,6,7,0,1,2,3,4,5,6,7};
    localparam int VP [NV] = '{2,2,2,2,2,2,2,2,4,4,4,4,4,4,4,4};
    localparam int VN [NV] = '{32,64,128,128,128,128,128,128,
                               32,64,128,128,128,128,128,128};

    always #2.5 clk = ~clk;

    audio_clk_div u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .bclk_sel(bclk_sel),
        .frame_sel(frame_sel), .bclk_o(bclk_o), .fclk_o(fclk_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Configure while stopped, enable, then measure one full frame.
    task automatic run_case(input int b, input int f, input int p, input int n);
        int k = 0, first_b = 0, cyc = 0, rises = 0, bhigh = 0, fhigh = 0;
        int bad_edge = 0, bad_run = 0, hrun = 0;
        bit pb, pf, done;
        string rb, rf;
        rb = (b == 0) ? "R2" : "R3";
        rf = (f > 2) ? "R5" : "R4";
        en = 1'b0; bclk_sel = b[0]; frame_sel = f[2:0];
        repeat (2) @(negedge clk);
        check(!bclk_o && !fclk_o, "R8 stopped low", {bclk_o, fclk_o}, 0);
        en = 1'b1;
        while (!fclk_o && k < 2000) begin
            @(negedge clk); k++;
            if (bclk_o && first_b == 0) first_b = k;
        end
        check(first_b == p / 2, "R8 first bclk high", first_b, p / 2);
        check(k == p * n / 2, "R8 first fclk rise", k, p * n / 2);
        pb = bclk_o; pf = fclk_o; done = 1'b0;
        while (!done && cyc < 2000) begin
            @(negedge clk); cyc++;
            if (bclk_o) begin bhigh++; hrun++; end
            if (fclk_o) fhigh++;
            if (bclk_o && !pb) rises++;
            if (!bclk_o && pb) begin
                if (hrun != p / 2) bad_run++;
                hrun = 0;
            end
            if ((fclk_o != pf) && !(pb && !bclk_o)) bad_edge++;
            if (fclk_o && !pf) done = 1'b1;
            pb = bclk_o; pf = fclk_o;
        end
        check(cyc == p * n, {rf, " frame cycles"}, cyc, p * n);
        check(rises == n, {rf, " bit periods per frame"}, rises, n);
        check(bhigh == n * p / 2 && bad_run == 0, {rb, " bclk duty"}, bhigh, n * p / 2);
        check(fhigh == p * n / 2, "R6 fclk duty", fhigh, p * n / 2);
        check(bad_edge == 0, "R7 frame edge on bclk fall", bad_edge, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int k;
        // R1: reset dominates an asserted enable.
        en = 1'b1;
        repeat (4) @(negedge clk);
        check(!bclk_o && !fclk_o, "R1 reset low", {bclk_o, fclk_o}, 0);
        en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bclk_o && !fclk_o, "R1 after release", {bclk_o, fclk_o}, 0);

        for (int i = 0; i < NV; i++) run_case(VB[i], VF[i], VP[i], VN[i]);

        // R8: stopping mid-frame clears both outputs and keeps them low.
        en = 1'b0; bclk_sel = 1'b0; frame_sel = 3'd0;
        repeat (2) @(negedge clk);
        en = 1'b1;
        repeat (40) @(negedge clk);
        check(fclk_o, "R8 fclk high before stop", fclk_o, 1);
        en = 1'b0;
        @(negedge clk);
        check(!bclk_o && !fclk_o, "R8 stop one cycle", {bclk_o, fclk_o}, 0);
        repeat (5) @(negedge clk);
        check(!bclk_o && !fclk_o, "R8 stays low", {bclk_o, fclk_o}, 0);

        // R9: fields changed mid-frame wait for the frame boundary.
        en = 1'b1;
        k = 0;
        while (!fclk_o && k < 2000) begin @(negedge clk); k++; end
        check(k == 32, "R9 setup rise", k, 32);
        bclk_sel = 1'b1; frame_sel = 3'd2;
        k = 0;
        while (fclk_o && k < 2000) begin @(negedge clk); k++; end
        check(k == 32, "R9 old ratio until boundary", k, 32);
        k = 0;
        while (!fclk_o && k < 2000) begin @(negedge clk); k++; end
        check(k == 256, "R9 new ratio after boundary", k, 256);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule